// File: doc/BRIEF.md
# Multi-Stream Golay Sequence Generator

This block builds one member of a family of binary Golay complementary pairs and streams it out. A start pulse selects one of eight streams, a length code (32 to 512 chips) and a bonding mode. The block then runs the pair recursion. It begins from two unit impulses and applies one delay and one weight per iteration, with log2(N) iterations for an N-chip result. Intermediate pairs live in two ping-pong buffers. Every iteration makes one full pass over N addresses, reading from one buffer and writing to the other.

When the last iteration is complete, the sequence is sent out one chip per cycle under a valid/ready handshake. The primary sequence appears on `o_chip` and its complementary partner on `o_comp`. A chip of -1 is encoded as bit 1 and +1 as bit 0. Streams differ only in their weight vectors. The delay order is the same for every stream, is not monotonic, and depends on the bonding mode.

Top module: `golay_seq_gen`

## Requirements
- R1: After reset `o_valid` and `o_last` are 0.
- R2: An accepted start yields exactly N = 2^(len+5) chips, each transferred on a cycle with `o_valid` and `i_ready` high. `o_last` is high only with the final chip. `o_valid` is 0 in the cycle after the final transfer.
- R3: The generator sets A0 = B0 = unit impulse at index 0. For k = 1..K it forms A_k(n) = W_k·A_{k-1}(n) + B_{k-1}(n-D_k) and B_k(n) = W_k·A_{k-1}(n) - B_{k-1}(n-D_k). Chip n of A_K appears on `o_chip` and chip n of B_K on `o_comp`, with bit 1 meaning -1.
- R4: Mode 0 (`i_mode`=0) accepts length codes 0,1,2 (32,64,128). Delays in iteration order are 2,1,4,8,16,32,64. Weights 1..5 per stream 0..7 (sign list) are: s0 ++--+, s1 -+--+, s2 -----, s3 +----, s4 ----+, s5 +---+, s6 ---+-, s7 +--+-. Weight 6 is - for length 64 and + for length 128. Weight 7 is +.
- R5: Mode 1 accepts codes 1..4 (64..512). Delays in order are 1,8,2,4,16,32,64,128,256. Weights 1..9 for streams 0/1 are ----+--++, for 2/3 ---+--+-+, for 4/5 ---+-++-+, and for 6/7 ---+++--+. The odd-numbered streams 1,3,5,7 use + for weight 1.
- R6: For every delivered pair, the aperiodic autocorrelations of `o_chip` and `o_comp` sum to 0 at every nonzero lag and to 2N at lag 0.
- R7: While `o_valid` is high and `i_ready` is low, `o_valid`, `o_chip`, `o_comp` and `o_last` hold their values.
- R8: A start with an unsupported mode/length pairing is ignored, and no output follows.
- R9: A start pulse that arrives while a sequence is being generated or streamed is ignored. The current sequence completes unchanged.
- R10: `o_valid` first rises K·N+1 clock edges after the edge that accepts the start (K = len+5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_start | input | 1 | Start pulse, taken only when idle |
| i_stream | input | 3 | Stream index 0..7 |
| i_len | input | 3 | Length code, N = 2^(code+5) |
| i_mode | input | 1 | 0: single-channel delays, 1: bonded delays |
| i_ready | input | 1 | Downstream accepts a chip |
| o_valid | output | 1 | Chip available |
| o_chip | output | 1 | Primary sequence chip (1 = -1) |
| o_comp | output | 1 | Complementary sequence chip (1 = -1) |
| o_last | output | 1 | Final chip of the sequence |

## Verification
The checker assumes that `i_start` is a pulse and that stream, length and mode are stable in the accepting cycle. It assumes nothing about `i_ready`. The chip-count property relies on the latched iteration count, so it takes for granted that the length code is only sampled on an accepted start. The stimulus changes inputs only on the falling edge. It drives `i_ready` with both full-rate and irregular stall patterns. It places the extra start pulses of the busy tests inside the generation phase and inside the streaming phase, and it changes their parameters so that any wrongful capture would show.

// File: rtl/gsg_pkg.sv
package gsg_pkg;

  localparam int GSG_MIN_LOG = 5;
  localparam int GSG_MAX_LOG = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_PRIME,
    ST_OUT
  } gsg_state_e;

  // log2 of the delay applied in iteration k (0-based)
  function automatic logic [3:0] delay_exp(input logic mode, input logic [3:0] k);
    logic [3:0] e;
    e = k;
    if (!mode) begin
      case (k)
        4'd0: e = 4'd1;
        4'd1: e = 4'd0;
        default: e = k;
      endcase
    end else begin
      case (k)
        4'd0: e = 4'd0;
        4'd1: e = 4'd3;
        4'd2: e = 4'd1;
        4'd3: e = 4'd2;
        default: e = k;
      endcase
    end
    return e;
  endfunction

  function automatic logic combo_ok(input logic mode, input logic [2:0] code);
    if (!mode) return (code <= 3'd2);
    return (code >= 3'd1) && (code <= 3'd4);
  endfunction

endpackage

// File: rtl/gsg_dpram.sv
module gsg_dpram #(
  parameter int DW = 2,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/gsg_weight_rom.sv
module gsg_weight_rom #(
  parameter int SW     = 3,
  parameter int CODE_W = 3,
  parameter int WLEN   = 9
) (
  input  logic [SW-1:0]     i_stream,
  input  logic [CODE_W-1:0] i_code,
  input  logic              i_mode,
  output logic [WLEN-1:0]   o_wneg
);
  // bit k = weight of iteration k, 1 means -1
  logic [8:0] tbl;

  always_comb begin
    tbl = '0;
    if (!i_mode) begin
      case (int'(i_stream))
        0: tbl[4:0] = 5'b01100;
        1: tbl[4:0] = 5'b01101;
        2: tbl[4:0] = 5'b11111;
        3: tbl[4:0] = 5'b11110;
        4: tbl[4:0] = 5'b01111;
        5: tbl[4:0] = 5'b01110;
        6: tbl[4:0] = 5'b10111;
        default: tbl[4:0] = 5'b10110;
      endcase
      tbl[5] = (int'(i_code) == 1);
    end else begin
      case (int'(i_stream) / 2)
        0: tbl[8:1] = 8'b00110111;
        1: tbl[8:1] = 8'b01011011;
        2: tbl[8:1] = 8'b01001011;
        default: tbl[8:1] = 8'b01100011;
      endcase
      tbl[0] = ~i_stream[0];
    end
  end

  assign o_wneg = WLEN'(tbl);
endmodule

// File: rtl/gsg_combine.sv
module gsg_combine (
  input  logic       first,
  input  logic       a_imp,
  input  logic       b_imp,
  input  logic       b_in,
  input  logic       w_neg,
  input  logic [1:0] qa,
  input  logic [1:0] qb,
  output logic [1:0] na,
  output logic [1:0] nb
);
  // sample = {present, negative}
  logic a_v, a_s, b_v, b_s, ws;

  always_comb begin
    a_v = first ? a_imp : qa[1];
    a_s = first ? 1'b0  : qa[0];
    b_v = first ? b_imp : (b_in & qb[1]);
    b_s = first ? 1'b0  : qb[0];
    ws  = w_neg ^ a_s;
    na  = {a_v | b_v, a_v ? ws : b_s};
    nb  = {a_v | b_v, a_v ? ws : ~b_s};
  end
endmodule

// File: rtl/golay_seq_gen.sv
module golay_seq_gen
  import gsg_pkg::*;
#(
  parameter int STREAMS = 8,
  parameter int MIN_LOG = GSG_MIN_LOG,
  parameter int MAX_LOG = GSG_MAX_LOG,
  parameter int CODE_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       i_start,
  input  logic [$clog2(STREAMS)-1:0] i_stream,
  input  logic [CODE_W-1:0]          i_len,
  input  logic                       i_mode,
  input  logic                       i_ready,
  output logic                       o_valid,
  output logic                       o_chip,
  output logic                       o_comp,
  output logic                       o_last
);
  localparam int SW = $clog2(STREAMS);
  localparam int AW = MAX_LOG;
  localparam int KW = $clog2(MAX_LOG + 1);
  localparam int DW = 2;

  gsg_state_e st;

  logic [MAX_LOG-1:0] wvec_in, wvec_q;
  logic               mode_q;
  logic [KW-1:0]      kmax_q, it_q, k_in;
  logic [AW-1:0]      nmax_q, n_q, out_idx;
  logic               busy, accept, fire;

  // pipeline stage between read and write
  logic          p_v, p_first, p_aimp, p_bimp, p_bok, p_w, p_dst;
  logic [AW-1:0] p_n;

  logic [3:0]    dexp;
  logic [AW-1:0] dly, rd_a, rd_b, out_rd;
  logic          dest_bank, last_n, last_it;
  logic [1:0]    qa [2];
  logic [1:0]    qb [2];
  logic [1:0]    src_a, src_b, na, nb;

  assign busy    = (st != ST_IDLE);
  assign accept  = !busy && i_start && combo_ok(i_mode, 3'(i_len));
  assign fire    = o_valid && i_ready;
  assign k_in    = KW'(i_len) + KW'(MIN_LOG);

  assign dexp      = delay_exp(mode_q, 4'(it_q));
  assign dly       = AW'(1) << dexp;
  assign dest_bank = it_q[0] ^ kmax_q[0];
  assign last_n    = (n_q == nmax_q);
  assign last_it   = (it_q == kmax_q);

  assign out_rd = (st == ST_OUT && fire) ? out_idx + AW'(1) : out_idx;
  assign rd_a   = (st == ST_RUN) ? n_q : out_rd;
  assign rd_b   = (st == ST_RUN) ? n_q - dly : out_rd;

  gsg_weight_rom #(.SW(SW), .CODE_W(CODE_W), .WLEN(MAX_LOG)) u_rom (
    .i_stream(i_stream),
    .i_code  (i_len),
    .i_mode  (i_mode),
    .o_wneg  (wvec_in)
  );

  assign src_a = p_dst ? qa[0] : qa[1];
  assign src_b = p_dst ? qb[0] : qb[1];

  gsg_combine u_comb (
    .first(p_first),
    .a_imp(p_aimp),
    .b_imp(p_bimp),
    .b_in (p_bok),
    .w_neg(p_w),
    .qa   (src_a),
    .qb   (src_b),
    .na   (na),
    .nb   (nb)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic we;
    assign we = p_v && (p_dst == 1'(b));

    gsg_dpram #(.DW(DW), .AW(AW)) u_mem_a (
      .clk(clk), .wr_en(we), .wr_addr(p_n), .wr_data(na),
      .rd_addr(rd_a), .rd_data(qa[b])
    );
    gsg_dpram #(.DW(DW), .AW(AW)) u_mem_b (
      .clk(clk), .wr_en(we), .wr_addr(p_n), .wr_data(nb),
      .rd_addr(rd_b), .rd_data(qb[b])
    );
  end

  // the last iteration always writes bank 0
  assign o_chip = qa[0][0];
  assign o_comp = qb[0][0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      o_valid <= 1'b0;
      o_last  <= 1'b0;
      p_v     <= 1'b0;
      p_first <= 1'b0;
      p_aimp  <= 1'b0;
      p_bimp  <= 1'b0;
      p_bok   <= 1'b0;
      p_w     <= 1'b0;
      p_dst   <= 1'b0;
      p_n     <= '0;
      mode_q  <= 1'b0;
      wvec_q  <= '0;
      kmax_q  <= '0;
      nmax_q  <= '0;
      it_q    <= '0;
      n_q     <= '0;
      out_idx <= '0;
    end else begin
      p_v <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            mode_q  <= i_mode;
            wvec_q  <= wvec_in;
            kmax_q  <= k_in - KW'(1);
            nmax_q  <= AW'((32'd1 << k_in) - 32'd1);
            it_q    <= '0;
            n_q     <= '0;
            out_idx <= '0;
            st      <= ST_RUN;
          end
        end
        ST_RUN: begin
          p_v     <= 1'b1;
          p_n     <= n_q;
          p_first <= (it_q == '0);
          p_aimp  <= (n_q == '0);
          p_bimp  <= (n_q == dly);
          p_bok   <= (n_q >= dly);
          p_w     <= wvec_q[it_q];
          p_dst   <= dest_bank;
          if (last_n) begin
            n_q <= '0;
            if (last_it) st <= ST_PRIME;
            else         it_q <= it_q + KW'(1);
          end else begin
            n_q <= n_q + AW'(1);
          end
        end
        ST_PRIME: begin
          st      <= ST_OUT;
          o_valid <= 1'b1;
          o_last  <= 1'b0;
        end
        default: begin
          if (fire) begin
            if (o_last) begin
              o_valid <= 1'b0;
              o_last  <= 1'b0;
              st      <= ST_IDLE;
            end else begin
              out_idx <= out_idx + AW'(1);
              o_last  <= ((out_idx + AW'(1)) == nmax_q);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/gsg_checker.sv
module gsg_checker #(
  parameter int AW     = 9,
  parameter int KW     = 4,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              i_start,
  input logic              i_mode,
  input logic [CODE_W-1:0] i_len,
  input logic              i_ready,
  input logic              o_valid,
  input logic              o_last,
  input logic              o_chip,
  input logic              o_comp,
  input logic              busy,
  input logic [KW-1:0]     kmax_q
);
  logic [AW:0] xfer_cnt;
  logic        legal;

  assign legal = i_mode ? (int'(i_len) >= 1 && int'(i_len) <= 4) : (int'(i_len) <= 2);

  always_ff @(posedge clk) begin
    if (rst)                     xfer_cnt <= '0;
    else if (o_valid && i_ready) xfer_cnt <= o_last ? '0 : xfer_cnt + 1'b1;
  end

  p_last_valid_r2: assert property (@(posedge clk) disable iff (rst)
    o_last |-> o_valid);

  p_last_count_r2: assert property (@(posedge clk) disable iff (rst)
    (o_valid && i_ready && o_last) |-> (int'(xfer_cnt) == (1 << (int'(kmax_q) + 1)) - 1));

  p_drop_after_last_r2: assert property (@(posedge clk) disable iff (rst)
    (o_valid && i_ready && o_last) |=> !o_valid);

  p_valid_while_busy_r2: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> busy);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !i_ready) |=> (o_valid && $stable(o_chip) && $stable(o_comp) && $stable(o_last)));

  p_bad_start_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && i_start && !legal) |=> !busy);
endmodule

bind golay_seq_gen gsg_checker #(.AW(AW), .KW(KW), .CODE_W(CODE_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .i_start(i_start),
  .i_mode (i_mode),
  .i_len  (i_len),
  .i_ready(i_ready),
  .o_valid(o_valid),
  .o_last (o_last),
  .o_chip (o_chip),
  .o_comp (o_comp),
  .busy   (busy),
  .kmax_q (kmax_q)
);

// File: tb/sim_golay_seq_gen.sv
`timescale 1ns/1ps
module sim_golay_seq_gen;
  logic       clk = 1'b0;
  logic       rst, i_start, i_mode, i_ready;
  logic [2:0] i_stream, i_len;
  logic       o_valid, o_chip, o_comp, o_last;

  always #4 clk = ~clk;

  golay_seq_gen u0 (
    .clk(clk), .rst(rst), .i_start(i_start), .i_stream(i_stream),
    .i_len(i_len), .i_mode(i_mode), .i_ready(i_ready),
    .o_valid(o_valid), .o_chip(o_chip), .o_comp(o_comp), .o_last(o_last)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  int base0 [8][5] = '{'{1,1,-1,-1,1}, '{-1,1,-1,-1,1}, '{-1,-1,-1,-1,-1}, '{1,-1,-1,-1,-1},
                       '{-1,-1,-1,-1,1}, '{1,-1,-1,-1,1}, '{-1,-1,-1,1,-1}, '{1,-1,-1,1,-1}};
  int tbl1 [4][9] = '{'{-1,-1,-1,-1,1,-1,-1,1,1}, '{-1,-1,-1,1,-1,-1,1,-1,1},
                      '{-1,-1,-1,1,-1,1,1,-1,1}, '{-1,-1,-1,1,1,1,-1,-1,1}};
  int dl0 [7] = '{2,1,4,8,16,32,64};
  int dl1 [9] = '{1,8,2,4,16,32,64,128,256};

  int ma [512];
  int mb [512];
  int ca [512];
  int cb [512];
  int mlen;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int wt(int s, int lc, int m, int k);
    if (m == 0) begin
      if (k < 5) return base0[s][k];
      if (k == 5) return (lc == 1) ? -1 : 1;
      return 1;
    end
    if (k == 0) return (s % 2 == 1) ? 1 : -1;
    return tbl1[s/2][k];
  endfunction

  task automatic build_model(int s, int lc, int m);
    int a [512];
    int b [512];
    int na [512];
    int nb [512];
    int kk;
    kk = lc + 5;
    mlen = 1 << kk;
    for (int n = 0; n < 512; n++) begin a[n] = 0; b[n] = 0; end
    a[0] = 1; b[0] = 1;
    for (int k = 0; k < kk; k++) begin
      int d, w, sh;
      d = (m == 0) ? dl0[k] : dl1[k];
      w = wt(s, lc, m, k);
      for (int n = 0; n < 512; n++) begin
        sh = (n >= d) ? b[n-d] : 0;
        na[n] = w * a[n] + sh;
        nb[n] = w * a[n] - sh;
      end
      for (int n = 0; n < 512; n++) begin a[n] = na[n]; b[n] = nb[n]; end
    end
    for (int n = 0; n < 512; n++) begin ma[n] = a[n]; mb[n] = b[n]; end
  endtask

  task automatic do_start(int s, int lc, int m);
    @(negedge clk);
    i_stream = 3'(s); i_len = 3'(lc); i_mode = 1'(m); i_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    i_start = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; i_start = 0; i_ready = 0; i_stream = 0; i_len = 0; i_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(o_valid == 0, "R1", "o_valid after reset", int'(o_valid), 0);
    check(o_last == 0, "R1", "o_last after reset", int'(o_last), 0);
    rst = 1'b0;
  endtask

  // stall: irregular ready; inject: extra start pulses while busy (R9)
  task automatic run_seq(int s, int lc, int m, bit stall, bit inject);
    int kk, cnt, idx, spin, last_err, hold_err, bad_a, bad_b, bad_lag, lag0;
    bit held, hv, hc, hb, hl, r;
    string gtag;
    kk = lc + 5;
    build_model(s, lc, m);
    i_ready = 0;
    do_start(s, lc, m);
    cnt = 0;
    while (!o_valid) begin
      @(negedge clk);
      cnt++;
      if (inject && cnt == 100) begin
        i_start = 1; i_stream = 3'((s + 3) % 8); i_len = 3'(m ? 1 : 0);
      end else begin
        i_start = 0;
      end
    end
    check(cnt == kk * (1 << kk) + 1, "R10", "first valid edge count", cnt, kk * (1 << kk) + 1);
    idx = 0; spin = 0; last_err = 0; hold_err = 0; held = 0;
    while (idx < mlen) begin
      if (held) begin
        if (o_valid != hv || o_chip != hc || o_comp != hb || o_last != hl) hold_err++;
      end
      r = stall ? ((spin % 3) != 0) : 1'b1;
      spin++;
      i_start = (inject && idx == 7) ? 1'b1 : 1'b0;
      if (inject && idx == 7) begin i_stream = 3'((s + 5) % 8); i_mode = ~i_mode; end
      held = 0;
      if (o_valid) begin
        if (r) begin
          ca[idx] = o_chip ? -1 : 1;
          cb[idx] = o_comp ? -1 : 1;
          if (o_last != (idx == mlen - 1)) last_err++;
          idx++;
        end else begin
          held = 1; hv = o_valid; hc = o_chip; hb = o_comp; hl = o_last;
        end
      end
      i_ready = r;
      @(negedge clk);
    end
    i_ready = 0; i_start = 0;
    check(o_valid == 0, "R2", "valid after final chip", int'(o_valid), 0);
    check(last_err == 0, "R2", "misplaced last flags", last_err, 0);
    if (stall) check(hold_err == 0, "R7", "outputs changed during stall", hold_err, 0);
    bad_a = 0; bad_b = 0;
    for (int n = 0; n < mlen; n++) begin
      if (ca[n] != ma[n]) bad_a++;
      if (cb[n] != mb[n]) bad_b++;
    end
    gtag = (m == 0) ? "R4" : "R5";
    check(bad_a == 0, gtag, $sformatf("primary mismatches s%0d len%0d", s, mlen), bad_a, 0);
    check(bad_b == 0, "R3", $sformatf("complement mismatches s%0d len%0d", s, mlen), bad_b, 0);
    if (inject) check(bad_a + bad_b == 0, "R9", "sequence altered by busy start", bad_a + bad_b, 0);
    bad_lag = 0; lag0 = 0;
    for (int n = 0; n < mlen; n++) lag0 += ca[n] * ca[n] + cb[n] * cb[n];
    for (int l = 1; l < mlen; l++) begin
      int acc;
      acc = 0;
      for (int n = 0; n + l < mlen; n++) acc += ca[n] * ca[n+l] + cb[n] * cb[n+l];
      if (acc != 0) bad_lag++;
    end
    check(bad_lag == 0, "R6", "lags with nonzero correlation sum", bad_lag, 0);
    check(lag0 == 2 * mlen, "R6", "zero-lag correlation sum", lag0, 2 * mlen);
  endtask

  task automatic t_invalid(int lc, int m);
    int seen;
    seen = 0;
    i_ready = 1;
    do_start(0, lc, m);
    repeat (80) begin
      @(negedge clk);
      if (o_valid) seen++;
    end
    i_ready = 0;
    check(seen == 0, "R8", $sformatf("valid cycles after bad start mode%0d code%0d", m, lc), seen, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    run_seq(0, 0, 0, 0, 0);
    run_seq(1, 0, 0, 1, 0);
    run_seq(7, 2, 0, 0, 0);
    run_seq(2, 1, 0, 1, 0);
    run_seq(0, 1, 1, 0, 0);
    run_seq(5, 2, 1, 1, 0);
    run_seq(6, 3, 1, 0, 0);
    run_seq(3, 4, 1, 1, 0);
    t_invalid(3, 0);
    t_invalid(0, 1);
    run_seq(4, 0, 0, 0, 1);
    run_seq(1, 1, 1, 1, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule